// File: doc/BRIEF.md
# Circular Paged Receive Buffer Allocator

This block manages the receive region of an 8 KB packet memory that is cut into 256-byte pages. A 5-bit configuration value gives the receive region pages 0 through that value. The pages above it are left to the transmit side. Incoming frame bytes arrive one per cycle from the MAC side. For each frame the block claims the next open page and stores the bytes from offset 4 onward. When the frame needs more room, it moves on to the next pages in turn, and page 0 follows the last receive page. When the frame closes, the block writes a 32-bit status word into the four bytes at the base of the frame's first page.

The CPU drains the queue one packet at a time with a release command. The packet released is always the oldest one stored. A flush command empties the whole region. When a frame finds no page, or runs out of pages partway through, a sticky full flag is raised. Every frame is then dropped until the CPU clears that flag, and the clear only takes effect while a page is free.

Top module: `rx_page_ring`

## Requirements
- R1: The receive region holds `cfg_rx_pages`+1 pages, numbered 0 to `cfg_rx_pages`. After reset `free_pages` equals that count, `head_page`, `pkt_count` and `rx_full` are 0, and no write is issued.
- R2: A frame whose first byte arrives while no page is free raises `rx_full`. None of that frame's bytes are written.
- R3: While `rx_full` is 1, every byte of every frame is dropped, even when pages are free. Free count and packet count are unchanged by such frames.
- R4: Each stored byte appears on the data write port one cycle after it is accepted. The address is page*256 + offset. The first byte of a frame goes to offset 4 of the page it claims.
- R5: A frame that fills a page continues at offset 0 of the next page. Page `cfg_rx_pages` is followed by page 0.
- R6: A frame that needs a page while none is free stops being written. Its pages return to the free pool, the next frame starts at its first page, `rx_full` is raised, and no status word is written for it.
- R7: One cycle after the last byte of a frame is accepted, a status word is written at the frame's first page base address (offset 0). Bits 15:0 hold the stored byte count, bits 23:16 the page count and bit 31 the abort mark; the other bits are 0.
- R8: An `in_abort` pulse during a frame ends it with bit 31 of its status set. The byte offered in that cycle is not stored, and the frame keeps its pages as a packet.
- R9: `cmd_release` frees the pages of the oldest stored packet. It also decrements `pkt_count` and advances `head_page` by that packet's page count, wrapping within the region. With no packet stored it has no effect.
- R10: `cmd_flush` makes all receive pages free and sets the next frame to start at page 0. It sets `head_page` and `pkt_count` to 0 and cancels a frame in progress. That frame's remaining bytes are dropped and no status is written for it.
- R11: `rx_full` falls only on `cmd_clr_full`, and only if `free_pages` is non-zero in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rx_pages | input | 5 | Highest receive page number; held static |
| in_valid | input | 1 | A frame byte is offered this cycle |
| in_first | input | 1 | Offered byte is the first of a frame |
| in_last | input | 1 | Offered byte is the last of a frame |
| in_data | input | 8 | Offered byte |
| in_abort | input | 1 | MAC-side abort of the current frame |
| cmd_release | input | 1 | Free the oldest stored packet |
| cmd_flush | input | 1 | Empty the whole receive region |
| cmd_clr_full | input | 1 | Request to clear the full flag |
| mem_we | output | 1 | Data byte write strobe |
| mem_addr | output | 13 | Data byte address |
| mem_wdata | output | 8 | Data byte |
| st_we | output | 1 | Status word write strobe |
| st_addr | output | 13 | Status word byte address (page base) |
| st_data | output | 32 | Status word |
| rx_full | output | 1 | Sticky receive-buffer-full flag |
| free_pages | output | 6 | Open receive pages |
| pkt_count | output | 6 | Stored packets not yet released |
| head_page | output | 5 | First page of the oldest stored packet |

## Verification
A wrong page pointer shows within one cycle as a wrong `mem_addr` on the next byte written. A corrupted free count shows at once on `free_pages`. If the count of a queued packet is wrong, nothing shows until that packet is released, which may be many frames later. `head_page` then moves by the wrong amount. So the bench releases every packet it stores and compares the pointer after each release. A full flag that sets or clears at the wrong moment first shows as writes that should or should not occur for the next frame. Every output is therefore compared on every clock, not only at frame ends.

// File: rtl/rx_page_ring.sv
module rx_page_ring #(
  parameter int TOTAL_PAGES = 32,
  parameter int PAGE_BYTES  = 256,
  localparam int PW = $clog2(TOTAL_PAGES),
  localparam int OW = $clog2(PAGE_BYTES),
  localparam int AW = PW + OW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] cfg_rx_pages,
  input  logic          in_valid,
  input  logic          in_first,
  input  logic          in_last,
  input  logic [7:0]    in_data,
  input  logic          in_abort,
  input  logic          cmd_release,
  input  logic          cmd_flush,
  input  logic          cmd_clr_full,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          st_we,
  output logic [AW-1:0] st_addr,
  output logic [31:0]   st_data,
  output logic          rx_full,
  output logic [PW:0]   free_pages,
  output logic [PW:0]   pkt_count,
  output logic [PW-1:0] head_page
);

  logic [PW:0]   n_pages;
  logic [PW-1:0] alloc_ptr, alloc_inc, cur_start, cur_page;
  logic [OW-1:0] cur_off;
  logic [PW:0]   cur_pages;
  logic [15:0]   byte_cnt;
  logic          active, dropping;
  logic [PW:0]   pg_q [TOTAL_PAGES];
  logic [PW-1:0] q_wr, q_rd;

  assign n_pages   = {1'b0, cfg_rx_pages} + (PW+1)'(1);
  assign alloc_inc = (alloc_ptr == cfg_rx_pages) ? '0 : alloc_ptr + 1'b1;

  logic vld, abt, start, start_ok, need_page, starve, take, wr_byte, finish, rel_go, full_set;
  assign vld       = in_valid && !cmd_flush;
  assign abt       = in_abort && !cmd_flush;
  assign start     = !active && !dropping && vld && in_first && !abt;
  assign start_ok  = start && !rx_full && free_pages != '0;
  assign need_page = active && vld && !abt && cur_off == '0;
  assign starve    = need_page && free_pages == '0;
  assign take      = start_ok || (need_page && !starve);
  assign wr_byte   = start_ok || (active && vld && !abt && !starve);
  assign finish    = (start_ok && in_last) || (active && ((vld && in_last && !starve) || abt));
  assign rel_go    = cmd_release && pkt_count != '0 && !cmd_flush;
  assign full_set  = (start && free_pages == '0) || starve;

  logic [PW:0]   pages_now, rel_amt, free_next, head_sum;
  logic [15:0]   bytes_now;
  logic [PW-1:0] start_pg, wpage, alloc_next;
  logic [OW-1:0] woff;

  assign pages_now = start_ok ? (PW+1)'(1) : cur_pages + (PW+1)'(take);
  assign bytes_now = start_ok ? 16'd1 : byte_cnt + 16'(wr_byte);
  assign start_pg  = start_ok ? alloc_ptr : cur_start;
  assign wpage     = take ? alloc_ptr : cur_page;
  assign woff      = start_ok ? OW'(4) : cur_off;
  assign rel_amt   = rel_go ? pg_q[q_rd] : '0;
  assign head_sum  = {1'b0, head_page} + rel_amt;

  always_comb begin
    free_next  = free_pages - (PW+1)'(take) + rel_amt + (starve ? cur_pages : '0);
    alloc_next = starve ? cur_start : (take ? alloc_inc : alloc_ptr);
    if (cmd_flush) begin
      free_next  = n_pages;
      alloc_next = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (finish) pg_q[q_wr] <= pages_now;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      st_we      <= 1'b0;
      st_addr    <= '0;
      st_data    <= '0;
      rx_full    <= 1'b0;
      free_pages <= n_pages;
      pkt_count  <= '0;
      head_page  <= '0;
      alloc_ptr  <= '0;
      cur_start  <= '0;
      cur_page   <= '0;
      cur_off    <= '0;
      cur_pages  <= '0;
      byte_cnt   <= '0;
      active     <= 1'b0;
      dropping   <= 1'b0;
      q_wr       <= '0;
      q_rd       <= '0;
    end else begin
      mem_we     <= wr_byte;
      mem_addr   <= {wpage, woff};
      mem_wdata  <= in_data;
      st_we      <= finish;
      st_addr    <= {start_pg, OW'(0)};
      st_data    <= {abt, 7'd0, 8'(pages_now), bytes_now};
      free_pages <= free_next;
      alloc_ptr  <= alloc_next;

      if (full_set)
        rx_full <= 1'b1;
      else if (cmd_clr_full && free_pages != '0)
        rx_full <= 1'b0;

      if (cmd_flush) begin
        active    <= 1'b0;
        dropping  <= (active || dropping) && !(in_valid && in_last) && !in_abort;
        q_wr      <= '0;
        q_rd      <= '0;
        pkt_count <= '0;
        head_page <= '0;
      end else begin
        if (start_ok) begin
          active    <= !in_last;
          cur_start <= alloc_ptr;
          cur_page  <= alloc_ptr;
          cur_off   <= OW'(5);
          cur_pages <= (PW+1)'(1);
          byte_cnt  <= 16'd1;
        end else if (start) begin
          dropping  <= !in_last;
        end else if (active) begin
          if (starve) begin
            active   <= 1'b0;
            dropping <= !in_last;
          end else if (finish) begin
            active   <= 1'b0;
          end else if (wr_byte) begin
            cur_off   <= cur_off + 1'b1;
            byte_cnt  <= bytes_now;
            cur_pages <= pages_now;
            if (take) cur_page <= alloc_ptr;
          end
        end else if (dropping && ((vld && in_last) || abt)) begin
          dropping <= 1'b0;
        end

        if (finish) q_wr <= q_wr + 1'b1;
        if (rel_go) begin
          q_rd      <= q_rd + 1'b1;
          head_page <= (head_sum >= n_pages) ? PW'(head_sum - n_pages) : PW'(head_sum);
        end
        pkt_count <= pkt_count + (PW+1)'(finish) - (PW+1)'(rel_go);
      end
    end
  end

endmodule

module rx_page_ring_chk #(
  parameter int PW = 5,
  parameter int OW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PW-1:0]    cfg_rx_pages,
  input logic             cmd_flush,
  input logic             cmd_clr_full,
  input logic             mem_we,
  input logic [PW+OW-1:0] mem_addr,
  input logic             st_we,
  input logic [PW+OW-1:0] st_addr,
  input logic             rx_full,
  input logic [PW:0]      free_pages,
  input logic [PW:0]      pkt_count
);

  AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    free_pages <= {1'b0, cfg_rx_pages} + 1'b1); // R1

  AST_WR_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr[PW+OW-1:OW] <= cfg_rx_pages); // R5

  AST_STATUS_AT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |-> (st_addr[OW-1:0] == '0 && st_addr[PW+OW-1:OW] <= cfg_rx_pages)); // R7

  AST_PKT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, pkt_count} + {1'b0, free_pages}) <= ({2'b0, cfg_rx_pages} + 1'b1)); // R9

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_flush |=> (free_pages == {1'b0, cfg_rx_pages} + 1'b1 && pkt_count == '0 && !mem_we && !st_we)); // R10

  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !cmd_clr_full) |=> rx_full); // R11

  AST_CLR_NEEDS_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && free_pages == '0) |=> rx_full); // R11

endmodule

bind rx_page_ring rx_page_ring_chk #(.PW(PW), .OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rx_pages(cfg_rx_pages), .cmd_flush(cmd_flush),
  .cmd_clr_full(cmd_clr_full), .mem_we(mem_we), .mem_addr(mem_addr), .st_we(st_we),
  .st_addr(st_addr), .rx_full(rx_full), .free_pages(free_pages), .pkt_count(pkt_count)
);

// File: tb/tb_rx_page_ring.sv
`timescale 1ns/1ps
module tb_rx_page_ring;
  localparam int NP = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  cfg_rx_pages = 5'(NP - 1);
  logic        in_valid = 0, in_first = 0, in_last = 0, in_abort = 0;
  logic [7:0]  in_data = 0;
  logic        cmd_release = 0, cmd_flush = 0, cmd_clr_full = 0;
  logic        mem_we, st_we, rx_full;
  logic [12:0] mem_addr, st_addr;
  logic [7:0]  mem_wdata;
  logic [31:0] st_data;
  logic [5:0]  free_pages, pkt_count;
  logic [4:0]  head_page;

  rx_page_ring dut (.*);

  always #4 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cycles = 0;

  task automatic chk(string tag, longint got, longint exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference
  int m_free, m_alloc, m_head, m_start, m_page, m_off, m_pages, m_bytes;
  bit m_active, m_drop, m_full;
  int pq[$];
  bit e_we, e_st;
  int e_addr, e_wdata, e_st_addr;
  logic [31:0] e_st_data;

  function automatic void m_status(bit ab);
    e_st = 1;
    e_st_addr = m_start * 256;
    e_st_data = {ab, 7'd0, 8'(m_pages), 16'(m_bytes)};
    pq.push_back(m_pages);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_free = NP; m_alloc = 0; m_head = 0; m_active = 0; m_drop = 0; m_full = 0;
      pq.delete(); e_we = 0; e_st = 0;
    end else begin
      bit vld, abt, setf, clr_ok;
      int relamt;
      e_we = 0; e_st = 0; setf = 0; relamt = 0;
      vld = in_valid && !cmd_flush;
      abt = in_abort && !cmd_flush;
      clr_ok = cmd_clr_full && m_free > 0;
      if (cmd_flush) begin
        m_free = NP; m_alloc = 0; m_head = 0; pq.delete();
        if (m_active || m_drop) m_drop = !(in_valid && in_last) && !in_abort;
        m_active = 0;
      end else begin
        if (cmd_release && pq.size() > 0) begin
          relamt = pq.pop_front();
          m_head = (m_head + relamt) % NP;
        end
        if (!m_active && !m_drop) begin
          if (vld && in_first && !abt) begin
            if (m_full || m_free == 0) begin
              if (m_free == 0) setf = 1;
              m_drop = !in_last;
            end else begin
              m_start = m_alloc; m_page = m_alloc; m_alloc = (m_alloc + 1) % NP; m_free--;
              e_we = 1; e_addr = m_page * 256 + 4; e_wdata = in_data;
              m_off = 5; m_pages = 1; m_bytes = 1;
              if (in_last) m_status(0); else m_active = 1;
            end
          end
        end else if (m_active) begin
          if (abt) begin
            m_status(1); m_active = 0;
          end else if (vld) begin
            if (m_off == 256) begin
              if (m_free == 0) begin
                setf = 1; m_free += m_pages; m_alloc = m_start; m_active = 0; m_drop = !in_last;
              end else begin
                m_page = m_alloc; m_alloc = (m_alloc + 1) % NP; m_free--; m_pages++; m_off = 0;
              end
            end
            if (m_active) begin
              e_we = 1; e_addr = m_page * 256 + m_off; e_wdata = in_data;
              m_off++; m_bytes++;
              if (in_last) begin m_status(0); m_active = 0; end
            end
          end
        end else if ((vld && in_last) || abt) begin
          m_drop = 0;
        end
        m_free += relamt;
      end
      if (setf) m_full = 1; else if (clr_ok) m_full = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 full", rx_full, m_full);
      chk("R9 free", free_pages, m_free);
      chk("R9 pkts", pkt_count, pq.size());
      chk("R9 head", head_page, m_head);
      chk("R4 we", mem_we, e_we);
      if (e_we) begin
        chk("R4 addr", mem_addr, e_addr);
        chk("R4 data", mem_wdata, e_wdata);
      end
      chk("R7 st_we", st_we, e_st);
      if (e_st) begin
        chk("R7 st_addr", st_addr, e_st_addr);
        chk("R7 st_data", st_data, e_st_data);
      end
    end
  end

  task automatic send(int len, bit close, int seed);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1; in_first = (i == 0); in_last = close && (i == len - 1);
      in_data = 8'(i * 7 + seed);
    end
    @(negedge clk);
    in_valid = 0; in_first = 0; in_last = 0;
  endtask

  task automatic pulse(int which);
    @(negedge clk);
    case (which)
      0: cmd_release = 1;
      1: cmd_flush = 1;
      2: cmd_clr_full = 1;
      default: in_abort = 1;
    endcase
    @(negedge clk);
    cmd_release = 0; cmd_flush = 0; cmd_clr_full = 0; in_abort = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    chk("R1 free after reset", free_pages, NP);
    chk("R1 full after reset", rx_full, 0);
    chk("R1 head after reset", head_page, 0);

    send(10, 1, 1); idle(2);
    chk("R7 pkt after short frame", pkt_count, 1);
    chk("R4 free after short frame", free_pages, 3);

    send(300, 1, 2); idle(2);
    chk("R5 two pages used", free_pages, 1);

    pulse(0); idle(1);
    chk("R9 release frees one", free_pages, 2);
    chk("R9 head moves", head_page, 1);

    send(20, 0, 3); pulse(3); idle(2);
    chk("R8 aborted frame kept", pkt_count, 2);
    chk("R8 pages kept", free_pages, 1);

    send(600, 1, 4); idle(2);
    chk("R6 starve sets full", rx_full, 1);
    chk("R6 pages returned", free_pages, 1);
    chk("R6 no packet added", pkt_count, 2);

    send(5, 1, 5); idle(2);
    chk("R3 dropped while full", pkt_count, 2);
    chk("R3 free unchanged", free_pages, 1);

    pulse(2); idle(1);
    chk("R11 clear with free page", rx_full, 0);

    pulse(0); pulse(0); pulse(0); idle(1);
    chk("R9 all released", free_pages, NP);
    chk("R9 empty release ignored", pkt_count, 0);
    chk("R9 head wrapped", head_page, 0);

    send(5, 1, 6); send(5, 1, 7); send(5, 1, 8);
    pulse(0); pulse(0); pulse(0); idle(1);
    send(300, 1, 9); idle(2);
    chk("R5 wrap frame pages", free_pages, NP - 2);

    send(10, 0, 10); pulse(1); send(4, 1, 11); idle(2);
    chk("R10 flush frees all", free_pages, NP);
    chk("R10 flush clears pkts", pkt_count, 0);
    chk("R10 flush clears head", head_page, 0);

    for (int k = 0; k < NP; k++) send(200, 1, 12 + k);
    idle(1);
    chk("R2 region filled", free_pages, 0);
    send(3, 1, 20); idle(2);
    chk("R2 full on no page", rx_full, 1);
    pulse(2); idle(1);
    chk("R11 clear blocked", rx_full, 1);
    pulse(1); pulse(2); idle(1);
    chk("R11 clear after flush", rx_full, 0);

    idle(3);
    finish_run();
  end
endmodule